// File: doc/BRIEF.md
# Core Interrupt Bid Unit

Each core carries one of these units. It watches the raised-vector broadcasts that an interrupt service port sends to every core. A broadcast counts only when the core's own table register is valid and holds the same page address as the broadcast. The unit then masks the 64-bit raised vector against the current core priority. It picks the highest enabled priority and places a bid for it on an external arbitration fabric, which is modelled here as grant and deny inputs.

A deny sends the unit quietly back to idle, and execution is never touched. A grant makes the unit request a dequeue of one message at the chosen priority. When the message arrives, the unit raises a one-cycle dispatch. The dispatch carries the context select, the priority and the whole message as the first register value. The unit then moves its core priority up to the priority of the interrupt it took.

Writing the table register starts a read of that table's raised vector. The read response is evaluated in the same way as a matching broadcast.

Top module: `irq_negotiator`

## Requirements
- R1: After reset, `bid_req`, `deq_req`, `disp_valid` and `rd_req` are low, `cur_prio` is 0 and the table register is invalid.
- R2: While the table register's valid bit is clear, no broadcast and no read response starts a bid.
- R3: A broadcast whose `bc_addr` differs from the table register's address starts no bid.
- R4: An accepted broadcast presented in cycle k raises `bid_req` for exactly cycle k+1. `bid_prio` is the index of the highest set bit of the vector whose index is above `cur_prio`. Bit i of a raised vector stands for priority i.
- R5: Bits at or below `cur_prio` are disabled. When no bit above `cur_prio` is set, no bid is made.
- R6: A deny (with grant low), sampled in the cycle after `bid_req`, returns the unit to idle without `deq_req` or `disp_valid`. The next accepted broadcast bids again.
- R7: A grant, sampled in the cycle after `bid_req`, raises `deq_req` in the next cycle with `deq_prio` equal to the bid priority. `deq_req` stays high until `deq_ack` is sampled.
- R8: The cycle after `deq_ack`, `disp_valid` is high for one cycle. `disp_msg` is the 48-bit message, laid out as context select [47:46], priority [45:40], handler index [39:32] and payload [31:0]. `disp_cs` and `disp_prio` carry the matching fields.
- R9: In the cycle after `disp_valid`, `cur_prio` equals the dispatched priority.
- R10: A write of the table register in cycle k raises `rd_req` for cycle k+1 with `rd_addr` equal to the written address. A read response to a valid table is evaluated like a matching broadcast.
- R11: Broadcasts that arrive while a bid, dequeue or dispatch is in progress are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tp_wr_en | input | 1 | Table register write strobe |
| tp_wr_addr | input | 40 | Page address written to the table register |
| tp_wr_valid | input | 1 | Valid bit written to the table register |
| rd_req | output | 1 | Raised-vector read request |
| rd_addr | output | 40 | Page address to read |
| rd_rsp_valid | input | 1 | Raised-vector read response strobe |
| rd_rsp_vec | input | 64 | Raised vector returned by the read |
| bc_valid | input | 1 | Broadcast strobe |
| bc_addr | input | 40 | Table page address of the broadcast |
| bc_vec | input | 64 | Broadcast raised vector |
| bid_req | output | 1 | Bid pulse |
| bid_prio | output | 6 | Priority bid for |
| bid_grant | input | 1 | Bid won |
| bid_deny | input | 1 | Bid lost |
| deq_req | output | 1 | Dequeue request |
| deq_prio | output | 6 | Priority queue to dequeue from |
| deq_ack | input | 1 | Dequeued message valid |
| deq_msg | input | 48 | Dequeued message |
| disp_valid | output | 1 | Dispatch pulse |
| disp_cs | output | 2 | Context select to load |
| disp_prio | output | 6 | Priority to load |
| disp_msg | output | 48 | Message handed over as first register |
| cur_prio | output | 6 | Current core priority |

## Verification
A table of raised vectors is broadcast at core priority 0, and every bid is denied. Each row separates a different encoder failure: only bit 0 set (at the level, so it must not bid), a single low bit, only the top bit, the top and bottom bits together, a lone middle bit in the upper word, an empty vector, and a full vector. Directed cases then cover the valid gate, an address mismatch, the read-on-write path, a full grant and dispatch with a late dequeue acknowledge, masking after the priority has been raised to 20, and a broadcast that lands while a bid is pending.

// File: rtl/irq_neg_pkg.sv
package irq_neg_pkg;
  localparam int PRIO_W       = 6;
  localparam int PRIO_N       = 1 << PRIO_W;
  localparam int CS_W         = 2;
  localparam int HND_W        = 8;
  localparam int PAY_W        = 32;
  localparam int MSG_W        = CS_W + PRIO_W + HND_W + PAY_W;
  localparam int MSG_PRIO_LSB = HND_W + PAY_W;
  localparam int MSG_CS_LSB   = MSG_PRIO_LSB + PRIO_W;
  localparam int ADDR_W       = 40;

  typedef enum logic [2:0] {
    S_IDLE, S_BID, S_WAIT, S_DEQ, S_DISP
  } neg_state_e;
endpackage

// File: rtl/irq_tbl_ptr.sv
module irq_tbl_ptr #(
  parameter int ADDR_W = irq_neg_pkg::ADDR_W,
  parameter int VEC_W  = irq_neg_pkg::PRIO_N
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_valid,
  input  logic              bc_valid,
  input  logic [ADDR_W-1:0] bc_addr,
  input  logic [VEC_W-1:0]  bc_vec,
  input  logic              rsp_valid,
  input  logic [VEC_W-1:0]  rsp_vec,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              evt_hit,
  output logic [VEC_W-1:0]  evt_vec
);
  logic [ADDR_W-1:0] addr_q;
  logic              vld_q;
  logic              rd_q;
  logic              bc_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      vld_q  <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      rd_q <= wr_en;
      if (wr_en) begin
        addr_q <= wr_addr;
        vld_q  <= wr_valid;
      end
    end
  end

  always_comb begin
    bc_hit  = bc_valid && vld_q && (bc_addr == addr_q);
    evt_hit = bc_hit || (rsp_valid && vld_q);
    evt_vec = bc_hit ? bc_vec : rsp_vec;
  end

  assign rd_req  = rd_q;
  assign rd_addr = addr_q;

  assert_rd_after_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_req && rd_addr == $past(wr_addr)));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int PRIO_W = irq_neg_pkg::PRIO_W,
  localparam int N     = 1 << PRIO_W
) (
  input  logic [N-1:0]      vec,
  input  logic [PRIO_W-1:0] cur_prio,
  output logic              any,
  output logic [PRIO_W-1:0] idx
);
  logic [N-1:0] en;

  for (genvar g = 0; g < N; g++) begin : g_en
    assign en[g] = vec[g] && (PRIO_W'(g) > cur_prio);
  end

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (en[i]) begin
        any = 1'b1;
        idx = PRIO_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_bid_fsm.sv
module irq_bid_fsm
  import irq_neg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_hit,
  input  logic              pick_any,
  input  logic [PRIO_W-1:0] pick_idx,
  input  logic              bid_grant,
  input  logic              bid_deny,
  input  logic              deq_ack,
  input  logic [MSG_W-1:0]  deq_msg,
  output logic              bid_req,
  output logic [PRIO_W-1:0] bid_prio,
  output logic              deq_req,
  output logic [PRIO_W-1:0] deq_prio,
  output logic              disp_valid,
  output logic [CS_W-1:0]   disp_cs,
  output logic [PRIO_W-1:0] disp_prio,
  output logic [MSG_W-1:0]  disp_msg,
  output logic [PRIO_W-1:0] cur_prio
);
  neg_state_e        state_q, state_d;
  logic [PRIO_W-1:0] sel_q;
  logic [MSG_W-1:0]  msg_q;
  logic [PRIO_W-1:0] prio_q;
  logic              sel_en, msg_en, prio_en;

  always_comb begin
    state_d = state_q;
    sel_en  = 1'b0;
    msg_en  = 1'b0;
    prio_en = 1'b0;
    case (state_q)
      S_IDLE: if (evt_hit && pick_any) begin
        state_d = S_BID;
        sel_en  = 1'b1;
      end
      S_BID:  state_d = S_WAIT;
      S_WAIT: if (bid_grant) state_d = S_DEQ;
              else if (bid_deny) state_d = S_IDLE;
      S_DEQ:  if (deq_ack) begin
        state_d = S_DISP;
        msg_en  = 1'b1;
      end
      S_DISP: begin
        state_d = S_IDLE;
        prio_en = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      sel_q   <= '0;
      msg_q   <= '0;
      prio_q  <= '0;
    end else begin
      state_q <= state_d;
      if (sel_en)  sel_q  <= pick_idx;
      if (msg_en)  msg_q  <= deq_msg;
      if (prio_en) prio_q <= msg_q[MSG_PRIO_LSB +: PRIO_W];
    end
  end

  assign bid_req    = (state_q == S_BID);
  assign bid_prio   = sel_q;
  assign deq_req    = (state_q == S_DEQ);
  assign deq_prio   = sel_q;
  assign disp_valid = (state_q == S_DISP);
  assign disp_cs    = msg_q[MSG_CS_LSB +: CS_W];
  assign disp_prio  = msg_q[MSG_PRIO_LSB +: PRIO_W];
  assign disp_msg   = msg_q;
  assign cur_prio   = prio_q;

  assert_bid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bid_req |=> !bid_req);
  assert_bid_above_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bid_req |-> (bid_prio > cur_prio));
  assert_deny_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT && bid_deny && !bid_grant) |=> (!bid_req && !deq_req && !disp_valid));
  assert_disp_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> $past(deq_req && deq_ack));
  assert_prio_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> (cur_prio == $past(disp_prio)));
endmodule

// File: rtl/irq_negotiator.sv
module irq_negotiator
  import irq_neg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tp_wr_en,
  input  logic [ADDR_W-1:0] tp_wr_addr,
  input  logic              tp_wr_valid,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_rsp_valid,
  input  logic [PRIO_N-1:0] rd_rsp_vec,
  input  logic              bc_valid,
  input  logic [ADDR_W-1:0] bc_addr,
  input  logic [PRIO_N-1:0] bc_vec,
  output logic              bid_req,
  output logic [PRIO_W-1:0] bid_prio,
  input  logic              bid_grant,
  input  logic              bid_deny,
  output logic              deq_req,
  output logic [PRIO_W-1:0] deq_prio,
  input  logic              deq_ack,
  input  logic [MSG_W-1:0]  deq_msg,
  output logic              disp_valid,
  output logic [CS_W-1:0]   disp_cs,
  output logic [PRIO_W-1:0] disp_prio,
  output logic [MSG_W-1:0]  disp_msg,
  output logic [PRIO_W-1:0] cur_prio
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              evt_hit;
  logic [PRIO_N-1:0] evt_vec;
  logic              pick_any;
  logic [PRIO_W-1:0] pick_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  irq_tbl_ptr #(.ADDR_W(ADDR_W), .VEC_W(PRIO_N)) u_tbl (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(tp_wr_en), .wr_addr(tp_wr_addr), .wr_valid(tp_wr_valid),
    .bc_valid(bc_valid), .bc_addr(bc_addr), .bc_vec(bc_vec),
    .rsp_valid(rd_rsp_valid), .rsp_vec(rd_rsp_vec),
    .rd_req(rd_req), .rd_addr(rd_addr),
    .evt_hit(evt_hit), .evt_vec(evt_vec)
  );

  irq_prio_pick #(.PRIO_W(PRIO_W)) u_pick (
    .vec(evt_vec), .cur_prio(cur_prio), .any(pick_any), .idx(pick_idx)
  );

  irq_bid_fsm u_fsm (
    .clk(clk), .rst_n(rst_int_n),
    .evt_hit(evt_hit), .pick_any(pick_any), .pick_idx(pick_idx),
    .bid_grant(bid_grant), .bid_deny(bid_deny),
    .deq_ack(deq_ack), .deq_msg(deq_msg),
    .bid_req(bid_req), .bid_prio(bid_prio),
    .deq_req(deq_req), .deq_prio(deq_prio),
    .disp_valid(disp_valid), .disp_cs(disp_cs), .disp_prio(disp_prio),
    .disp_msg(disp_msg), .cur_prio(cur_prio)
  );
endmodule

// File: tb/irq_negotiator_tb.sv
module irq_negotiator_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tp_wr_en = 1'b0;
  logic [39:0] tp_wr_addr = '0;
  logic        tp_wr_valid = 1'b0;
  logic        rd_req;
  logic [39:0] rd_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [63:0] rd_rsp_vec = '0;
  logic        bc_valid = 1'b0;
  logic [39:0] bc_addr = '0;
  logic [63:0] bc_vec = '0;
  logic        bid_req;
  logic [5:0]  bid_prio;
  logic        bid_grant = 1'b0;
  logic        bid_deny = 1'b0;
  logic        deq_req;
  logic [5:0]  deq_prio;
  logic        deq_ack = 1'b0;
  logic [47:0] deq_msg = '0;
  logic        disp_valid;
  logic [1:0]  disp_cs;
  logic [5:0]  disp_prio;
  logic [47:0] disp_msg;
  logic [5:0]  cur_prio;

  int checks = 0;
  int errors = 0;

  localparam logic [39:0] TBL_A = 40'h12_3456_7000;
  localparam logic [47:0] MSG   = {2'd2, 6'd20, 8'h5A, 32'hCAFE_0001};

  typedef struct packed {
    logic [63:0] vec;
    logic        hit;
    logic [5:0]  prio;
  } row_t;

  localparam row_t ROWS [8] = '{
    '{64'h0000_0000_0000_0001, 1'b0, 6'd0},
    '{64'h0000_0000_0000_0002, 1'b1, 6'd1},
    '{64'h8000_0000_0000_0000, 1'b1, 6'd63},
    '{64'h8000_0000_0000_0001, 1'b1, 6'd63},
    '{64'h0000_0010_0000_0000, 1'b1, 6'd36},
    '{64'h0000_0000_0000_0000, 1'b0, 6'd0},
    '{64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 6'd63},
    '{64'h0000_0000_0000_00F0, 1'b1, 6'd7}
  };

  always #10 clk = ~clk;

  irq_negotiator u_dut (
    .clk(clk), .rst_n(rst_n),
    .tp_wr_en(tp_wr_en), .tp_wr_addr(tp_wr_addr), .tp_wr_valid(tp_wr_valid),
    .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_vec(rd_rsp_vec),
    .bc_valid(bc_valid), .bc_addr(bc_addr), .bc_vec(bc_vec),
    .bid_req(bid_req), .bid_prio(bid_prio),
    .bid_grant(bid_grant), .bid_deny(bid_deny),
    .deq_req(deq_req), .deq_prio(deq_prio),
    .deq_ack(deq_ack), .deq_msg(deq_msg),
    .disp_valid(disp_valid), .disp_cs(disp_cs), .disp_prio(disp_prio),
    .disp_msg(disp_msg), .cur_prio(cur_prio)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bc(input logic [39:0] a, input logic [63:0] v);
    bc_valid = 1'b1; bc_addr = a; bc_vec = v;
    @(negedge clk);
    bc_valid = 1'b0; bc_vec = '0;
  endtask

  task automatic deny_bid();
    bid_deny = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bid_deny = 1'b0;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 bid_req", 64'(bid_req), 0);
    chk("R1 deq_req", 64'(deq_req), 0);
    chk("R1 disp_valid", 64'(disp_valid), 0);
    chk("R1 rd_req", 64'(rd_req), 0);
    chk("R1 cur_prio", 64'(cur_prio), 0);

    // R2 invalid table: reset address 0 matches, valid bit blocks
    send_bc(40'h0, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R2 no bid while invalid", 64'(bid_req), 0);
    rd_rsp_valid = 1'b1; rd_rsp_vec = 64'h10;
    @(negedge clk);
    rd_rsp_valid = 1'b0;
    chk("R2 rsp ignored while invalid", 64'(bid_req), 0);

    // R10 pointer write starts a read
    tp_wr_en = 1'b1; tp_wr_addr = TBL_A; tp_wr_valid = 1'b1;
    @(negedge clk);
    tp_wr_en = 1'b0;
    chk("R10 rd_req", 64'(rd_req), 1);
    chk("R10 rd_addr", 64'(rd_addr), 64'(TBL_A));
    @(negedge clk);
    chk("R10 rd_req single", 64'(rd_req), 0);
    rd_rsp_valid = 1'b1; rd_rsp_vec = 64'h20;
    @(negedge clk);
    rd_rsp_valid = 1'b0;
    chk("R10 rsp bid", 64'(bid_req), 1);
    chk("R10 rsp prio", 64'(bid_prio), 5);
    deny_bid();

    // R4 R5 R6 table of vectors at priority 0, each bid denied
    foreach (ROWS[i]) begin
      send_bc(TBL_A, ROWS[i].vec);
      chk("R4 bid_req", 64'(bid_req), 64'(ROWS[i].hit));
      if (ROWS[i].hit) begin
        chk("R4 bid_prio", 64'(bid_prio), 64'(ROWS[i].prio));
        deny_bid();
        chk("R6 no deq after deny", 64'(deq_req), 0);
        chk("R6 no disp after deny", 64'(disp_valid), 0);
      end else begin
        chk("R5 no bid", 64'(bid_req), 0);
      end
    end

    // R3 address mismatch
    send_bc(TBL_A ^ 40'h1000, 64'hFF00);
    chk("R3 mismatch ignored", 64'(bid_req), 0);

    // R7 R8 R9 grant and dispatch
    send_bc(TBL_A, 64'h0000_0000_0010_0200);
    chk("R4 bid 20", 64'(bid_prio), 20);
    bid_grant = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bid_grant = 1'b0;
    chk("R7 deq_req", 64'(deq_req), 1);
    chk("R7 deq_prio", 64'(deq_prio), 20);
    @(negedge clk);
    chk("R7 deq_req held", 64'(deq_req), 1);
    chk("R7 no early disp", 64'(disp_valid), 0);
    deq_ack = 1'b1; deq_msg = MSG;
    @(negedge clk);
    deq_ack = 1'b0; deq_msg = '0;
    chk("R8 disp_valid", 64'(disp_valid), 1);
    chk("R8 disp_cs", 64'(disp_cs), 2);
    chk("R8 disp_prio", 64'(disp_prio), 20);
    chk("R8 disp_msg", 64'(disp_msg), 64'(MSG));
    chk("R7 deq_req dropped", 64'(deq_req), 0);
    @(negedge clk);
    chk("R8 disp single", 64'(disp_valid), 0);
    chk("R9 cur_prio", 64'(cur_prio), 20);

    // R5 masking at priority 20
    send_bc(TBL_A, 64'h0000_0000_0010_0400);
    chk("R5 at or below masked", 64'(bid_req), 0);
    send_bc(TBL_A, 64'h0000_0000_0030_0000);
    chk("R5 above enabled", 64'(bid_req), 1);
    chk("R5 bid 21", 64'(bid_prio), 21);

    // R11 broadcast during wait is dropped
    @(negedge clk);
    bc_valid = 1'b1; bc_addr = TBL_A; bc_vec = 64'h100_0000_0000;
    bid_deny = 1'b1;
    @(negedge clk);
    bc_valid = 1'b0; bc_vec = '0; bid_deny = 1'b0;
    chk("R11 busy bc dropped", 64'(bid_req), 0);
    @(negedge clk);
    chk("R11 still idle", 64'(bid_req), 0);
    chk("R11 no deq", 64'(deq_req), 0);

    // R6 re-evaluation after deny
    send_bc(TBL_A, 64'h100_0000_0000);
    chk("R6 rebid", 64'(bid_req), 1);
    chk("R6 rebid prio", 64'(bid_prio), 40);
    deny_bid();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule